// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the address of each beat of a four-beat burst on a synchronous burst memory interface. The surrounding controller gives it three things: a load strobe, an active-low advance enable, and the external address. When the load strobe is accepted, the block captures the whole external address. After that, only the two least significant bits change, and only on clocks where the advance enable is low. The upper bits stay as they were loaded.

An order-select input chooses how the low bits move through the burst. Linear order counts up by one modulo four. Interleaved order XORs the loaded low bits with a running beat count. Interleaved is the intended default, so integrators tie the select high when they have no preference. A new load is allowed on any clock and replaces any burst in progress. When neither load nor advance is asserted, the burst is suspended and the address holds.

The output is registered. The address changes on the clock edge that samples the strobe and is valid for the whole following cycle.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted, and after its release until the first load, `beatAddr` is all zeros.
- R2: On an edge where `loadStrobe` is 1, `beatAddr` becomes `extAddr` unmodified after that edge. This holds whatever the value of `advN`, so load takes priority over advance.
- R3: Bits above bit 1 of `beatAddr` change only on an edge where `loadStrobe` is 1.
- R4: With `orderSel` = 0 (linear), each advance edge (`advN` = 0, `loadStrobe` = 0) adds one modulo 4 to bits [1:0]. A start of 01 gives 01, 10, 11, 00.
- R5: With `orderSel` = 1 (interleaved), bits [1:0] after the k-th advance since the load equal the loaded bits XOR (k mod 4). A start of 01 gives 01, 00, 11, 10. A start of 10 gives 10, 11, 00, 01.
- R6: The fourth advance after a load (the fifth beat) returns bits [1:0] to the loaded value, and the same four-beat pattern repeats.
- R7: On an edge where `loadStrobe` = 0 and `advN` = 1, `beatAddr` does not change (suspend). The burst then resumes from the beat where it stopped.
- R8: A load in the middle of a burst restarts the beat count. The next advance gives the second beat of the new start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| loadStrobe | input | 1 | Capture `extAddr` and start a burst (active high) |
| advN | input | 1 | Advance to the next beat (active low) |
| orderSel | input | 1 | 1 = interleaved order, 0 = linear order |
| extAddr | input | ADDR_W | External start address |
| beatAddr | output | ADDR_W | Current beat address |

## Verification
A wrong beat count or a corrupted stored start value appears in bits [1:0] of `beatAddr` one cycle after the advance that used it. It does not wait for the end of the burst. The bench therefore compares the address after every edge against a model it builds from the requirements alone.

Some faults only show up later in a burst:
- A dropped beat-count clear on reload is visible at the first advance after the reload.
- A failure to wrap is visible at the fourth advance.
- A slip during suspend is visible on the idle cycle itself.

Corrupted upper bits appear at once, on the first edge without a load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LOW_W = 2;
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobeT;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStrobe,
  input  logic             advN,
  output seqStrobeT        strb,
  output logic [LOW_W-1:0] beatCnt
);
  always_comb begin
    strb.load = loadStrobe;
    strb.step = !loadStrobe && !advN;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          beatCnt <= '0;
    else if (strb.load) beatCnt <= '0;
    else if (strb.step) beatCnt <= beatCnt + 1'b1;
  end

  // R8: a load always restarts the beat count
  a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> (beatCnt == '0));

  // R7: idle cycle leaves the count untouched
  a_r7_hold_count: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStrobe && advN) |=> $stable(beatCnt));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  input  logic [LOW_W-1:0]  beatCnt,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] beatAddr
);
  localparam int UP_W = ADDR_W - LOW_W;

  logic [UP_W-1:0]  upperQ;
  logic [LOW_W-1:0] startLow;
  logic [LOW_W-1:0] lowNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ   <= '0;
      startLow <= '0;
    end else if (strb.load) begin
      upperQ   <= extAddr[ADDR_W-1:LOW_W];
      startLow <= extAddr[LOW_W-1:0];
    end
  end

  always_comb begin
    if (orderSel) lowNow = startLow ^ beatCnt;
    else          lowNow = startLow + beatCnt;
  end

  assign beatAddr = {upperQ, lowNow};

  // R2: the loaded address appears unmodified
  a_r2_load_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (beatAddr == $past(extAddr)));

  // R3: upper bits move only with a load
  a_r3_upper_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(beatAddr[ADDR_W-1:LOW_W]));

  // R4: linear step adds one modulo four
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !orderSel) |=> (orderSel || lowNow == $past(lowNow) + 2'd1));
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStrobe,
  input  logic              advN,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] beatAddr
);
  seqStrobeT        strb;
  logic [LOW_W-1:0] beatCnt;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .advN(advN),
    .strb(strb), .beatCnt(beatCnt)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .beatCnt(beatCnt),
    .orderSel(orderSel), .extAddr(extAddr), .beatAddr(beatAddr)
  );
endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadStrobe = 1'b0;
  logic          advN = 1'b1;
  logic          orderSel = 1'b1;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] beatAddr;

  int vecCnt = 0;
  int errCnt = 0;

  logic [AW-3:0] mUpper = '0;
  logic [1:0]    mStart = '0;
  logic [1:0]    mK = '0;

  always #2.5 clk = ~clk;

  burst_seq #(.ADDR_W(AW)) u_burst_seq (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .advN(advN),
    .orderSel(orderSel), .extAddr(extAddr), .beatAddr(beatAddr)
  );

  function automatic logic [AW-1:0] modelAddr();
    logic [1:0] lo;
    lo = orderSel ? (mStart ^ mK) : (mStart + mK);
    return {mUpper, lo};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    vecCnt++;
    if (beatAddr !== exp) begin
      errCnt++;
      $display("FAIL %s: got %h expected %h", req, beatAddr, exp);
    end
  endtask

  // Drive on the falling edge; sample just after the next rising edge.
  task automatic cycle(input logic ld, input logic an, input logic [AW-1:0] a,
                       input string req);
    @(negedge clk);
    loadStrobe = ld; advN = an; extAddr = a;
    @(posedge clk);
    #1;
    if (ld) begin mUpper = a[AW-1:2]; mStart = a[1:0]; mK = '0; end
    else if (!an) mK = mK + 2'd1;
    check(req, modelAddr());
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", '0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", '0);
  endtask

  task automatic t_linear();
    orderSel = 1'b0;
    cycle(1'b1, 1'b1, 20'hA5C31, "R2");
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 20'h0, "R4");
    check("R6", 20'hA5C31);
    cycle(1'b0, 1'b0, 20'h0, "R4");
  endtask

  task automatic t_interleave();
    orderSel = 1'b1;
    cycle(1'b1, 1'b1, 20'h33331, "R2");
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 20'h0, "R5");
    check("R6", 20'h33331);
    cycle(1'b1, 1'b1, 20'h0F0F2, "R2");
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 20'h0, "R5");
    check("R5", 20'h0F0F1);
    cycle(1'b0, 1'b0, 20'hFFFFF, "R3");
  endtask

  task automatic t_suspend();
    orderSel = 1'b1;
    cycle(1'b1, 1'b1, 20'h12343, "R2");
    cycle(1'b0, 1'b0, 20'h0, "R5");
    cycle(1'b0, 1'b1, 20'hFFFFF, "R7");
    cycle(1'b0, 1'b1, 20'h00000, "R7");
    check("R7", 20'h12342);
    cycle(1'b0, 1'b0, 20'h0, "R7");
  endtask

  task automatic t_override();
    orderSel = 1'b0;
    cycle(1'b1, 1'b1, 20'h55550, "R2");
    cycle(1'b0, 1'b0, 20'h0, "R4");
    cycle(1'b0, 1'b0, 20'h0, "R4");
    cycle(1'b1, 1'b0, 20'hABCD3, "R2");
    check("R2", 20'hABCD3);
    cycle(1'b0, 1'b0, 20'h0, "R8");
    check("R8", 20'hABCD0);
  endtask

  initial begin
    t_reset();
    t_linear();
    t_interleave();
    t_suspend();
    t_override();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    #50000;
    errCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule